// File: doc/BRIEF.md
# FFT output exponent normaliser

This block brings the results of a block-floating-point FFT back to one common binary point. Every result word leaves the transform with a two-part exponent: a signed 5-bit pass-wide weighting value shared by the whole transform, and a 2-bit tag carried by the word itself. The block forms the word's exponent from these two parts. It subtracts that exponent from a universal exponent chosen by the user, and uses the difference as an arithmetic right-shift amount for the 16-bit data word.

Tags 00, 01, 10 and 11 stand for offsets of -1, 0, +1 and +2 relative to the pass-wide value. The block does not decode them. It adds the raw tag value, which is always one above the offset. The user compensates by supplying a universal exponent one larger than the wanted one; for an N-point transform, log2(N)+1 is then enough. All exponent arithmetic is 4 bits wide and wraps modulo 16. A negative pass-wide value, flagged by its sign bit, forces the largest shift of 15 places.

The real and imaginary parts of one complex result can share the block on alternate cycles. The real part is presented first and its shift amount is computed and held. The imaginary part that follows reuses that held amount and ignores its own exponent inputs. Results appear two clock cycles after the input is sampled, with a valid flag and the part flag alongside.

Top module: `fft_out_norm`

## Requirements
- R1: While reset (rst_n low) is asserted and after it is released with no input, out_valid is 0 and out_data is 0.
- R2: For a real sample (in_part = 0) with gwr bit 4 = 0, the shift amount is (uexp - (gwr[3:0] + tag)) modulo 16, where tag is added as its raw unsigned value 0..3.
- R3: For a real sample with gwr bit 4 = 1 (negative pass-wide value), the shift amount is 15 whatever tag and uexp are.
- R4: out_data is in_data arithmetically shifted right by the shift amount: the result equals floor(in_data / 2^shift) with in_data read as signed two's complement, so the sign bit is replicated and a shift of 0 passes the word unchanged.
- R5: A sample taken with in_valid = 1 at a rising edge produces out_valid = 1 after the second following rising edge, with out_part equal to its in_part; out_valid is 0 in every cycle that does not correspond to a sampled input.
- R6: An imaginary sample (in_part = 1) ignores its gwr, tag and uexp and is shifted by the amount computed for the most recent real sample (0 if none has occurred since reset).
- R7: When uexp is smaller than gwr[3:0] + tag, the 4-bit difference wraps: for example uexp = 0, gwr = 3, tag = 2 gives a shift of 11.
- R8: In cycles where no result is produced, out_data keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_part | input | 1 | 0 = real part (computes shift), 1 = imaginary part (reuses shift) |
| gwr | input | 5 | Pass-wide weighting value, two's complement |
| tag | input | 2 | Per-word tag, added as raw value |
| uexp | input | 4 | Universal exponent, already biased by +1 |
| in_data | input | 16 | Signed data word |
| out_valid | output | 1 | Normalised result present |
| out_part | output | 1 | Part flag of the result |
| out_data | output | 16 | Normalised signed data word |

## Verification
The bench goes after the 4-bit wrap of the shift difference; a design that widened or saturated the subtraction would return a small shift or zero instead of 11. It drives negative pass-wide values with tags and universal exponents that would otherwise give small shifts, which exposes a missing clamp. Imaginary samples carry deliberately different exponent inputs, so a design that recomputed the shift for them, or updated the held value on them, would shift by the wrong amount. Negative data words at every shift reveal a logical shift or a rounding shift in place of the floor-style arithmetic shift, and idle gaps show whether the output word is held and whether out_valid respects the two-cycle latency.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  localparam int NRM_DATA_W = 16;
  localparam int NRM_TAG_W  = 2;

  typedef enum logic {
    PART_RE = 1'b0,
    PART_IM = 1'b1
  } part_e;

endpackage

// File: rtl/nrm_shift_calc.sv
module nrm_shift_calc #(
  parameter int SH_W  = 4,
  parameter int TAG_W = 2,
  localparam int GWR_W = SH_W + 1
) (
  input  logic [GWR_W-1:0] gwr,
  input  logic [TAG_W-1:0] tag,
  input  logic [SH_W-1:0]  uexp,
  output logic [SH_W-1:0]  shift_now
);

  // Word exponent: raw tag added, bias folded into uexp by the user
  function automatic logic [SH_W-1:0] word_exp(
    input logic [SH_W-1:0]  g_lo,
    input logic [TAG_W-1:0] t
  );
    return g_lo + SH_W'(t);
  endfunction

  // Shift code: 4-bit wrapping difference, or all ones when clamped
  function automatic logic [SH_W-1:0] shift_code(
    input logic            g_neg,
    input logic [SH_W-1:0] ue,
    input logic [SH_W-1:0] e
  );
    logic [SH_W-1:0] diff;
    diff = ue - e;
    return g_neg ? {SH_W{1'b1}} : diff;
  endfunction

  logic [SH_W-1:0] exp_now;
  logic            clamp;

  assign exp_now   = word_exp(gwr[SH_W-1:0], tag);
  assign clamp     = gwr[GWR_W-1];
  assign shift_now = shift_code(clamp, uexp, exp_now);

endmodule

// File: rtl/nrm_shift_hold.sv
module nrm_shift_hold
  import nrm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_part,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SH_W-1:0]   shift_now,
  output logic              s1_valid,
  output logic              s1_part,
  output logic [DATA_W-1:0] s1_data,
  output logic [SH_W-1:0]   shift_used
);

  logic take_shift;
  assign take_shift = in_valid && (part_e'(in_part) == PART_RE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_part    <= 1'b0;
      s1_data    <= '0;
      shift_used <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_part <= in_part;
        s1_data <= in_data;
      end
      if (take_shift) begin
        shift_used <= shift_now;
      end
    end
  end

endmodule

// File: rtl/nrm_asr.sv
module nrm_asr #(
  parameter int DATA_W = 16,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_part,
  input  logic [DATA_W-1:0] s1_data,
  input  logic [SH_W-1:0]   shift_used,
  output logic              out_valid,
  output logic              out_part,
  output logic [DATA_W-1:0] out_data
);

  // Logarithmic barrel: stage k shifts by 2^k when shift bit k is set
  logic signed [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = $signed(s1_data);

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = shift_used[k] ? (stg[k] >>> (2 ** k)) : stg[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_part  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_part <= s1_part;
        out_data <= stg[SH_W];
      end
    end
  end

endmodule

// File: rtl/fft_out_norm.sv
module fft_out_norm #(
  parameter int DATA_W = nrm_pkg::NRM_DATA_W,
  parameter int TAG_W  = nrm_pkg::NRM_TAG_W,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int GWR_W = SH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_part,
  input  logic [GWR_W-1:0]  gwr,
  input  logic [TAG_W-1:0]  tag,
  input  logic [SH_W-1:0]   uexp,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_part,
  output logic [DATA_W-1:0] out_data
);

  logic [SH_W-1:0]   shift_now;
  logic [SH_W-1:0]   shift_used;
  logic              s1_valid;
  logic              s1_part;
  logic [DATA_W-1:0] s1_data;

  nrm_shift_calc #(
    .SH_W  (SH_W),
    .TAG_W (TAG_W)
  ) u_calc (
    .gwr       (gwr),
    .tag       (tag),
    .uexp      (uexp),
    .shift_now (shift_now)
  );

  nrm_shift_hold #(
    .DATA_W (DATA_W),
    .SH_W   (SH_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_part    (in_part),
    .in_data    (in_data),
    .shift_now  (shift_now),
    .s1_valid   (s1_valid),
    .s1_part    (s1_part),
    .s1_data    (s1_data),
    .shift_used (shift_used)
  );

  nrm_asr #(
    .DATA_W (DATA_W),
    .SH_W   (SH_W)
  ) u_asr (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid   (s1_valid),
    .s1_part    (s1_part),
    .s1_data    (s1_data),
    .shift_used (shift_used),
    .out_valid  (out_valid),
    .out_part   (out_part),
    .out_data   (out_data)
  );

endmodule

// File: rtl/fft_out_norm_chk.sv
module fft_out_norm_chk #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2,
  parameter int SH_W   = 4,
  parameter int GWR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_part,
  input logic [GWR_W-1:0]  gwr,
  input logic [TAG_W-1:0]  tag,
  input logic [SH_W-1:0]   uexp,
  input logic              s1_valid,
  input logic [DATA_W-1:0] s1_data,
  input logic [SH_W-1:0]   shift_used,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  // R2
  shift_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_part && !gwr[GWR_W-1]) |=>
      (SH_W'(shift_used + $past(gwr[SH_W-1:0]) + SH_W'($past(tag))) == $past(uexp)));

  // R3
  clamp_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_part && gwr[GWR_W-1]) |=> (&shift_used));

  // R6
  imag_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_part) |=> $stable(shift_used));

  // R5
  stage_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R5
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R4
  pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && shift_used == '0) |=> (out_data == $past(s1_data)));

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_data[DATA_W-1] == $past(s1_data[DATA_W-1])));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_data));

endmodule

bind fft_out_norm fft_out_norm_chk #(
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W),
  .SH_W   (SH_W),
  .GWR_W  (GWR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_part    (in_part),
  .gwr        (gwr),
  .tag        (tag),
  .uexp       (uexp),
  .s1_valid   (s1_valid),
  .s1_data    (s1_data),
  .shift_used (shift_used),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/fft_out_norm_tb.sv
`timescale 1ns/1ps
module fft_out_norm_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_part = 1'b0;
  logic [4:0]  gwr = '0;
  logic [1:0]  tag = '0;
  logic [3:0]  uexp = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_part;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int held_sh = 0;
  logic [15:0] last_out = '0;
  bit done = 1'b0;

  typedef struct {
    logic        part;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  fft_out_norm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_part   (in_part),
    .gwr       (gwr),
    .tag       (tag),
    .uexp      (uexp),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_part  (out_part),
    .out_data  (out_data)
  );

  // Independent model: signed exponent arithmetic folded modulo 16
  function automatic int model_shift(input logic [4:0] g, input logic [1:0] t,
                                     input logic [3:0] ue);
    int gs;
    int d;
    gs = int'($signed(g));
    if (gs < 0) return 15;
    d = int'(ue) - (gs + int'(t));
    return ((d % 16) + 16) % 16;
  endfunction

  // Floor division by a power of two
  function automatic logic [15:0] model_div(input logic [15:0] d, input int sh);
    int v;
    int p;
    int q;
    v = int'($signed(d));
    p = 1 << sh;
    if (v >= 0) q = v / p;
    else q = -((-v + p - 1) / p);
    return q[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic part, input logic [4:0] g, input logic [1:0] t,
                      input logic [3:0] ue, input logic [15:0] d, input string req);
    exp_t e;
    if (!part) held_sh = model_shift(g, t, ue);
    e.part = part;
    e.data = model_div(d, held_sh);
    e.req  = req;
    sb.push_back(e);
    in_valid = 1'b1;
    in_part  = part;
    gwr      = g;
    tag      = t;
    uexp     = ue;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each produced result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check("R5", 32'(out_valid), 32'd0, "unexpected out_valid");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, 32'(out_data), 32'(e.data), "out_data");
        check("R5", 32'(out_part), 32'(e.part), "out_part");
        last_out = e.data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(out_valid), 32'd0, "out_valid in reset");
    check("R1", 32'(out_data), 32'd0, "out_data in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 32'(out_valid), 32'd0, "out_valid after reset");
    check("R1", 32'(out_data), 32'd0, "out_data after reset");

    // R5: latency of one isolated sample; exponent 3, shift 2
    send(1'b0, 5'd2, 2'd1, 4'd5, 16'h4000, "R2");
    check("R5", 32'(out_valid), 32'd0, "out_valid one cycle after sample");
    @(negedge clk);
    check("R5", 32'(out_valid), 32'd1, "out_valid two cycles after sample");
    repeat (2) @(negedge clk);

    // R2: several exponent combinations
    send(1'b0, 5'd0, 2'd0, 4'd1, 16'h7FFF, "R2");
    send(1'b0, 5'd7, 2'd3, 4'd15, 16'h1234, "R2");
    send(1'b0, 5'd1, 2'd2, 4'd9, 16'hC000, "R2");
    // R4: shift 0 passes data, negative data floors
    send(1'b0, 5'd3, 2'd1, 4'd4, 16'h9235, "R4");
    send(1'b0, 5'd0, 2'd0, 4'd2, 16'hFFFF, "R4");
    send(1'b0, 5'd0, 2'd0, 4'd5, 16'h8001, "R4");
    // R3: negative pass-wide value clamps to 15
    send(1'b0, 5'b10000, 2'd3, 4'd3, 16'h8000, "R3");
    send(1'b0, 5'b11111, 2'd0, 4'd0, 16'h7FFF, "R3");
    send(1'b0, 5'b10101, 2'd1, 4'd12, 16'hA5A5, "R3");
    // R7: wrap of the 4-bit difference, shift 11
    send(1'b0, 5'd3, 2'd2, 4'd0, 16'h8000, "R7");
    send(1'b0, 5'd15, 2'd3, 4'd1, 16'h6000, "R7");
    // R6: imaginary reuses the real shift (3), own inputs ignored
    send(1'b0, 5'd1, 2'd0, 4'd4, 16'h4000, "R6");
    send(1'b1, 5'b10000, 2'd3, 4'd0, 16'hF000, "R6");
    send(1'b1, 5'd0, 2'd0, 4'd0, 16'h0FF0, "R6");
    repeat (4) @(negedge clk);

    // R8: output holds across idle cycles
    repeat (3) begin
      check("R8", 32'(out_data), 32'(last_out), "out_data held while idle");
      check("R5", 32'(out_valid), 32'd0, "out_valid low while idle");
      @(negedge clk);
    end

    // Mixed traffic: real/imaginary pairs with gaps
    for (int i = 0; i < 300; i++) begin
      send(1'b0, 5'($urandom), 2'($urandom), 4'($urandom), 16'($urandom), "R2");
      send(1'b1, 5'($urandom), 2'($urandom), 4'($urandom), 16'($urandom), "R6");
      if (($urandom % 4) == 0) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R5", 32'(sb.size()), 32'd0, "results outstanding at end");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule